// File: doc/BRIEF.md
# Exception Vector and Entry Sequencer

This block sits beside the execute stage of a processor core. Each cycle it collects the exception requests raised by the instruction in flight: a trap instruction with a 4-bit operand, a conditional overflow trap, a bounds check, a divide, and an illegal opcode. It also takes the result of an interrupt-acknowledge bus cycle. From these it picks one exception. For that exception it emits one entry record: the vector number, the vector table byte address, the program counter to save, a copy of the status register, the new status register, and a short-frame flag.

An instruction-caused exception always wins over an interrupt that finishes acknowledgement in the same cycle. In that case the interrupt result is held and is taken in the first later cycle that has no instruction request. An acknowledge that ends in a bus error means that no device responded. That case becomes the spurious-interrupt vector with a short frame, and never a bus-error exception. A vector delivered by a responding device is used unchanged, including the uninitialized-interrupt value 15.

Every entry record appears on the outputs one clock after the request that produced it.

Top module: `exc_entry_seq`

## Requirements
- R1: While reset is low, and on the first clock after release, `exc_valid` is 0 and all record outputs are 0.
- R2: A divide raises an exception only when `div_zero` is 1. The bounds check raises one only when `chk_fail` is 1, and the overflow trap only when `ovf_flag` is 1. With no qualified request and no interrupt to take, `exc_valid` stays 0.
- R3: The vector numbers are: illegal opcode 4, divide by zero 5, bounds check 6, overflow trap 7, and trap instruction 32 + `trap_num`.
- R4: When several instruction requests are qualified in one cycle, the order from highest to lowest is illegal opcode, divide by zero, bounds check, overflow trap, trap instruction.
- R5: An instruction request beats an interrupt-acknowledge result that ends in the same cycle. The interrupt is held and is taken in the first later cycle that has no instruction request.
- R6: An acknowledge that ends with `iack_berr`=1 produces vector 24 with `exc_short_frame`=1. It never produces vector 2, the bus-error vector.
- R7: An acknowledge that ends with `iack_berr`=0 uses `iack_vec` unchanged, so 15 stays 15, and sets `exc_short_frame`=0.
- R8: `exc_saved_pc` is `next_pc` for instruction exceptions and `instr_pc` for interrupts. Both are sampled in the cycle the entry is selected.
- R9: `exc_saved_sr` is `sr_in` from the selecting cycle. `exc_new_sr` is that same value with bit 13 (supervisor) set to 1 and bit 15 (trace) cleared to 0.
- R10: `exc_vaddr` equals `exc_vector` shifted left by two.
- R11: `exc_valid` is high for exactly one cycle per selected entry, one clock after the selecting cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ill_op | input | 1 | Fetched first word matches no legal opcode |
| div_op | input | 1 | A divide instruction is executing |
| div_zero | input | 1 | The divisor is zero |
| chk_op | input | 1 | A bounds-check instruction is executing |
| chk_fail | input | 1 | The bounds check failed |
| ovf_op | input | 1 | An overflow-trap instruction is executing |
| ovf_flag | input | 1 | The overflow condition is true |
| trap_op | input | 1 | A trap instruction is executing |
| trap_num | input | 4 | Operand field of the trap instruction |
| iack_done | input | 1 | The interrupt-acknowledge cycle ended this cycle |
| iack_berr | input | 1 | The acknowledge ended in a bus error |
| iack_vec | input | 8 | Vector byte from the responding device |
| instr_pc | input | 32 | Address of the current or next-to-run instruction |
| next_pc | input | 32 | Address of the following instruction |
| sr_in | input | 16 | Current status register |
| exc_valid | output | 1 | One-cycle entry pulse |
| exc_vector | output | 8 | Selected vector number |
| exc_vaddr | output | 10 | Vector table byte address |
| exc_saved_pc | output | 32 | Program counter to push |
| exc_saved_sr | output | 16 | Status register copy to push |
| exc_new_sr | output | 16 | Status register on entry |
| exc_short_frame | output | 1 | Short stack-frame format (spurious interrupt) |

## Verification
The assertions check the following on every cycle:
- A spurious entry carries vector 24, and the bus-error vector never appears.
- Every entry enters supervisor mode with trace cleared.
- The table address tracks the vector.
- A qualified instruction request always fires next cycle with the following-instruction address.
- A held interrupt fires once the execute stage is quiet, and a quiet cycle with nothing held produces nothing.

Only the bench's scenarios show the following: the exact vector chosen under each priority collision, trap operand folding, pass-through of device vectors such as 15, and that a deferred interrupt carries the status register and PC of the cycle in which it is finally taken.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int VEC_W = 8;

  localparam logic [VEC_W-1:0] VEC_ILLEGAL  = 8'd4;
  localparam logic [VEC_W-1:0] VEC_DIVZERO  = 8'd5;
  localparam logic [VEC_W-1:0] VEC_BOUNDS   = 8'd6;
  localparam logic [VEC_W-1:0] VEC_OVERFLOW = 8'd7;
  localparam logic [VEC_W-1:0] VEC_BUSERR   = 8'd2;
  localparam logic [VEC_W-1:0] VEC_SPURIOUS = 8'd24;
  localparam logic [VEC_W-1:0] VEC_TRAPBASE = 8'd32;

  // Byte address of a vector table slot (4-byte entries)
  function automatic logic [VEC_W+1:0] vec_table_addr(input logic [VEC_W-1:0] v);
    return {v, 2'b00};
  endfunction

  // Status register on exception entry: supervisor set, trace cleared
  function automatic logic [15:0] sr_on_entry(input logic [15:0] sr,
                                              input int s_bit, input int t_bit);
    logic [15:0] r;
    r = sr;
    r[s_bit] = 1'b1;
    r[t_bit] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/exc_req_decode.sv
module exc_req_decode
  import exc_entry_pkg::*;
#(
  parameter int TRAP_W = 4
) (
  input  logic              ill_op,
  input  logic              div_op,
  input  logic              div_zero,
  input  logic              chk_op,
  input  logic              chk_fail,
  input  logic              ovf_op,
  input  logic              ovf_flag,
  input  logic              trap_op,
  input  logic [TRAP_W-1:0] trap_num,
  output logic              instr_hit,
  output logic [VEC_W-1:0]  instr_vec
);
  localparam int NREQ = 5;

  logic [NREQ-1:0]  req;
  logic [VEC_W-1:0] vec_tab [NREQ];

  // index 0 is highest priority
  assign req[0] = ill_op;
  assign req[1] = div_op & div_zero;
  assign req[2] = chk_op & chk_fail;
  assign req[3] = ovf_op & ovf_flag;
  assign req[4] = trap_op;

  assign vec_tab[0] = VEC_ILLEGAL;
  assign vec_tab[1] = VEC_DIVZERO;
  assign vec_tab[2] = VEC_BOUNDS;
  assign vec_tab[3] = VEC_OVERFLOW;
  assign vec_tab[4] = VEC_TRAPBASE + VEC_W'(trap_num);

  assign instr_hit = |req;

  always_comb begin
    instr_vec = '0;
    for (int i = NREQ - 1; i >= 0; i--) begin
      if (req[i]) instr_vec = vec_tab[i];
    end
  end
endmodule

// File: rtl/exc_irq_hold.sv
module exc_irq_hold
  import exc_entry_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iack_done,
  input  logic             iack_berr,
  input  logic [VEC_W-1:0] iack_vec,
  input  logic             instr_hit,
  output logic             irq_ready,
  output logic [VEC_W-1:0] irq_vec,
  output logic             irq_short,
  output logic             pend_v
);
  logic             pend_short;
  logic [VEC_W-1:0] pend_vec;
  logic [VEC_W-1:0] live_vec;
  logic             take;

  // no responder: spurious vector, never the bus-error vector
  assign live_vec  = iack_berr ? VEC_SPURIOUS : iack_vec;

  assign irq_ready = pend_v | iack_done;
  assign irq_vec   = pend_v ? pend_vec   : live_vec;
  assign irq_short = pend_v ? pend_short : iack_berr;
  assign take      = irq_ready & ~instr_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v     <= 1'b0;
      pend_vec   <= '0;
      pend_short <= 1'b0;
    end else if (take && pend_v) begin
      // held result leaves; a fresh acknowledge takes its place
      pend_v     <= iack_done;
      pend_vec   <= live_vec;
      pend_short <= iack_berr;
    end else if (iack_done && !take) begin
      pend_v     <= 1'b1;
      pend_vec   <= live_vec;
      pend_short <= iack_berr;
    end
  end
endmodule

// File: rtl/exc_frame_build.sv
module exc_frame_build
  import exc_entry_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int SR_W     = 16,
  parameter int SR_S_BIT = 13,
  parameter int SR_T_BIT = 15
) (
  input  logic             instr_hit,
  input  logic [VEC_W-1:0] instr_vec,
  input  logic             irq_ready,
  input  logic [VEC_W-1:0] irq_vec,
  input  logic             irq_short,
  input  logic [PC_W-1:0]  instr_pc,
  input  logic [PC_W-1:0]  next_pc,
  input  logic [SR_W-1:0]  sr_in,
  output logic             fire,
  output logic [VEC_W-1:0] vec,
  output logic [VEC_W+1:0] vaddr,
  output logic [PC_W-1:0]  pc_save,
  output logic [SR_W-1:0]  sr_save,
  output logic [SR_W-1:0]  sr_new,
  output logic             short_frame
);
  assign fire        = instr_hit | irq_ready;
  assign vec         = instr_hit ? instr_vec : irq_vec;
  assign vaddr       = vec_table_addr(vec);
  // traps resume after the trapping instruction; interrupts resume at it
  assign pc_save     = instr_hit ? next_pc : instr_pc;
  assign sr_save     = sr_in;
  assign sr_new      = SR_W'(sr_on_entry(16'(sr_in), SR_S_BIT, SR_T_BIT));
  assign short_frame = ~instr_hit & irq_short;
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int SR_W     = 16,
  parameter int TRAP_W   = 4,
  parameter int SR_S_BIT = 13,
  parameter int SR_T_BIT = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ill_op,
  input  logic              div_op,
  input  logic              div_zero,
  input  logic              chk_op,
  input  logic              chk_fail,
  input  logic              ovf_op,
  input  logic              ovf_flag,
  input  logic              trap_op,
  input  logic [TRAP_W-1:0] trap_num,
  input  logic              iack_done,
  input  logic              iack_berr,
  input  logic [7:0]        iack_vec,
  input  logic [PC_W-1:0]   instr_pc,
  input  logic [PC_W-1:0]   next_pc,
  input  logic [SR_W-1:0]   sr_in,
  output logic              exc_valid,
  output logic [7:0]        exc_vector,
  output logic [9:0]        exc_vaddr,
  output logic [PC_W-1:0]   exc_saved_pc,
  output logic [SR_W-1:0]   exc_saved_sr,
  output logic [SR_W-1:0]   exc_new_sr,
  output logic              exc_short_frame
);
  logic             instr_hit;
  logic [VEC_W-1:0] instr_vec;
  logic             irq_ready, irq_short, pend_v;
  logic [VEC_W-1:0] irq_vec;
  logic             fire, short_frame;
  logic [VEC_W-1:0] vec;
  logic [VEC_W+1:0] vaddr;
  logic [PC_W-1:0]  pc_save;
  logic [SR_W-1:0]  sr_save, sr_new;

  exc_req_decode #(.TRAP_W(TRAP_W)) u_dec (
    .ill_op(ill_op), .div_op(div_op), .div_zero(div_zero),
    .chk_op(chk_op), .chk_fail(chk_fail), .ovf_op(ovf_op),
    .ovf_flag(ovf_flag), .trap_op(trap_op), .trap_num(trap_num),
    .instr_hit(instr_hit), .instr_vec(instr_vec)
  );

  exc_irq_hold u_irq (
    .clk(clk), .rst_n(rst_n), .iack_done(iack_done), .iack_berr(iack_berr),
    .iack_vec(iack_vec), .instr_hit(instr_hit), .irq_ready(irq_ready),
    .irq_vec(irq_vec), .irq_short(irq_short), .pend_v(pend_v)
  );

  exc_frame_build #(.PC_W(PC_W), .SR_W(SR_W), .SR_S_BIT(SR_S_BIT),
                    .SR_T_BIT(SR_T_BIT)) u_frm (
    .instr_hit(instr_hit), .instr_vec(instr_vec), .irq_ready(irq_ready),
    .irq_vec(irq_vec), .irq_short(irq_short), .instr_pc(instr_pc),
    .next_pc(next_pc), .sr_in(sr_in), .fire(fire), .vec(vec), .vaddr(vaddr),
    .pc_save(pc_save), .sr_save(sr_save), .sr_new(sr_new),
    .short_frame(short_frame)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exc_valid       <= 1'b0;
      exc_vector      <= '0;
      exc_vaddr       <= '0;
      exc_saved_pc    <= '0;
      exc_saved_sr    <= '0;
      exc_new_sr      <= '0;
      exc_short_frame <= 1'b0;
    end else begin
      exc_valid <= fire;
      if (fire) begin
        exc_vector      <= vec;
        exc_vaddr       <= vaddr;
        exc_saved_pc    <= pc_save;
        exc_saved_sr    <= sr_save;
        exc_new_sr      <= sr_new;
        exc_short_frame <= short_frame;
      end
    end
  end
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
  parameter int PC_W     = 32,
  parameter int SR_W     = 16,
  parameter int SR_S_BIT = 13,
  parameter int SR_T_BIT = 15
) (
  input logic            clk,
  input logic            rst_n,
  input logic            instr_hit,
  input logic            pend_v,
  input logic            iack_done,
  input logic [PC_W-1:0] next_pc,
  input logic            exc_valid,
  input logic [7:0]      exc_vector,
  input logic [9:0]      exc_vaddr,
  input logic [PC_W-1:0] exc_saved_pc,
  input logic [SR_W-1:0] exc_new_sr,
  input logic            exc_short_frame
);
  assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!instr_hit && !pend_v && !iack_done) |=> !exc_valid);

  assert_instr_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    instr_hit |=> (exc_valid && !exc_short_frame));

  assert_irq_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_hit && iack_done) |=> pend_v);

  assert_held_taken_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_v && !instr_hit) |=> exc_valid);

  assert_trap_pc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    instr_hit |=> (exc_saved_pc == $past(next_pc)));

  assert_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_short_frame) |-> (exc_vector == 8'd24));

  assert_no_buserr_vec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (exc_vector != 8'd2));

  assert_entry_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (exc_new_sr[SR_S_BIT] && !exc_new_sr[SR_T_BIT]));

  assert_table_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (exc_vaddr[9:2] == exc_vector && exc_vaddr[1:0] == 2'b00));
endmodule

bind exc_entry_seq exc_entry_seq_chk #(
  .PC_W(PC_W), .SR_W(SR_W), .SR_S_BIT(SR_S_BIT), .SR_T_BIT(SR_T_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .instr_hit(instr_hit), .pend_v(pend_v),
  .iack_done(iack_done), .next_pc(next_pc), .exc_valid(exc_valid),
  .exc_vector(exc_vector), .exc_vaddr(exc_vaddr), .exc_saved_pc(exc_saved_pc),
  .exc_new_sr(exc_new_sr), .exc_short_frame(exc_short_frame)
);

// File: tb/exc_entry_seq_tb.sv
`timescale 1ns/1ps
module exc_entry_seq_tb;
  logic        clk = 0, rst_n = 0;
  logic        ill_op, div_op, div_zero, chk_op, chk_fail, ovf_op, ovf_flag, trap_op;
  logic [3:0]  trap_num;
  logic        iack_done, iack_berr;
  logic [7:0]  iack_vec;
  logic [31:0] instr_pc, next_pc;
  logic [15:0] sr_in;
  logic        exc_valid, exc_short_frame;
  logic [7:0]  exc_vector;
  logic [9:0]  exc_vaddr;
  logic [31:0] exc_saved_pc;
  logic [15:0] exc_saved_sr, exc_new_sr;

  int errors = 0, checks = 0;
  bit done = 0;

  // bench model state: held interrupt
  bit         m_pend = 0, m_pshort = 0;
  logic [7:0] m_pvec = 0;
  // expected record
  bit          e_valid, e_short;
  logic [7:0]  e_vec;
  logic [31:0] e_pc;
  logic [15:0] e_sr;
  bit          e_instr;

  always #2 clk = ~clk;

  exc_entry_seq u_dut (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] iack_to_vec(input bit berr, input logic [7:0] v);
    return berr ? 8'd24 : v;
  endfunction

  task automatic idle();
    ill_op = 0; div_op = 0; div_zero = 0; chk_op = 0; chk_fail = 0;
    ovf_op = 0; ovf_flag = 0; trap_op = 0; trap_num = 0;
    iack_done = 0; iack_berr = 0; iack_vec = 0;
  endtask

  // compute expected from inputs now on the pins, advance model, then check
  task automatic step();
    bit hit;
    logic [7:0] iv;
    hit = 1; iv = 0;
    if (ill_op) iv = 8'd4;
    else if (div_op && div_zero) iv = 8'd5;
    else if (chk_op && chk_fail) iv = 8'd6;
    else if (ovf_op && ovf_flag) iv = 8'd7;
    else if (trap_op) iv = 8'd32 + {4'd0, trap_num};
    else hit = 0;
    e_instr = hit;
    e_sr = sr_in;
    if (hit) begin
      e_valid = 1; e_vec = iv; e_pc = next_pc; e_short = 0;
      if (iack_done) begin
        m_pend = 1; m_pvec = iack_to_vec(iack_berr, iack_vec); m_pshort = iack_berr;
      end
    end else if (m_pend) begin
      e_valid = 1; e_vec = m_pvec; e_pc = instr_pc; e_short = m_pshort;
      m_pend = 0;
    end else if (iack_done) begin
      e_valid = 1; e_vec = iack_to_vec(iack_berr, iack_vec); e_pc = instr_pc;
      e_short = iack_berr;
    end else e_valid = 0;
    @(negedge clk);
    chk(exc_valid == e_valid, "R11/R2 valid", exc_valid, e_valid);
    if (e_valid && exc_valid) begin
      if (e_instr) chk(exc_vector == e_vec, "R3/R4 vector", exc_vector, e_vec);
      else chk(exc_vector == e_vec, "R6/R7 irq vector", exc_vector, e_vec);
      chk(exc_short_frame == e_short, "R6 short frame", exc_short_frame, e_short);
      chk(exc_saved_pc == e_pc, "R8 saved pc", exc_saved_pc, e_pc);
      chk(exc_saved_sr == e_sr, "R9 saved sr", exc_saved_sr, e_sr);
      chk(exc_new_sr == ((e_sr | 16'h2000) & 16'h7fff), "R9 new sr",
          exc_new_sr, (e_sr | 16'h2000) & 16'h7fff);
      chk(exc_vaddr == {e_vec, 2'b00}, "R10 vaddr", exc_vaddr, {e_vec, 2'b00});
    end
    idle();
  endtask

  task automatic set_ctx();
    instr_pc = $urandom & 32'hffff_fffe;
    next_pc  = instr_pc + 32'd2 + (($urandom % 3) * 2);
    sr_in    = 16'($urandom);
  endtask

  initial begin : watchdog
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    idle(); set_ctx();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(exc_valid == 0 && exc_vector == 0 && exc_saved_pc == 0 && exc_new_sr == 0,
        "R1 reset", exc_valid, 0);
    rst_n = 1;
    @(negedge clk);
    chk(exc_valid == 0, "R1 after release", exc_valid, 0);

    // R2: unqualified requests do nothing
    set_ctx(); div_op = 1; chk_op = 1; ovf_op = 1; step();
    // R3: each vector individually
    set_ctx(); ill_op = 1; step();
    set_ctx(); div_op = 1; div_zero = 1; step();
    set_ctx(); chk_op = 1; chk_fail = 1; step();
    set_ctx(); ovf_op = 1; ovf_flag = 1; step();
    set_ctx(); trap_op = 1; trap_num = 4'hf; step();
    // R4: all at once -> illegal wins; then div beats trap
    set_ctx(); ill_op = 1; div_op = 1; div_zero = 1; chk_op = 1; chk_fail = 1;
    ovf_op = 1; ovf_flag = 1; trap_op = 1; step();
    set_ctx(); div_op = 1; div_zero = 1; trap_op = 1; trap_num = 4'h3; step();
    // R7: vector 15 passes through unchanged
    set_ctx(); iack_done = 1; iack_vec = 8'd15; step();
    // R6: bus error ending -> spurious 24, short frame
    set_ctx(); iack_done = 1; iack_berr = 1; iack_vec = 8'd2; step();
    // R5: instruction wins, interrupt deferred over two busy cycles
    set_ctx(); trap_op = 1; trap_num = 4'h1; iack_done = 1; iack_berr = 1; step();
    set_ctx(); chk_op = 1; chk_fail = 1; step();
    set_ctx(); step();
    set_ctx(); step();

    // random mix
    for (int i = 0; i < 3000; i++) begin
      set_ctx();
      ill_op   = ($urandom % 16) == 0;
      div_op   = ($urandom % 6) == 0;  div_zero = $urandom % 2;
      chk_op   = ($urandom % 6) == 0;  chk_fail = $urandom % 2;
      ovf_op   = ($urandom % 6) == 0;  ovf_flag = $urandom % 2;
      trap_op  = ($urandom % 8) == 0;  trap_num = 4'($urandom);
      if (!m_pend && ($urandom % 4) == 0) begin
        iack_done = 1; iack_berr = ($urandom % 3) == 0;
        iack_vec = (($urandom % 4) == 0) ? 8'd15 : 8'(64 + $urandom % 192);
      end
      step();
    end
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule